// File: doc/BRIEF.md
# Four-State Sequencer with a Shared Saturating Timer

This block is a small Moore sequencer that steps through four states in a fixed ring: idle, fixed-hold, gated-hold and exit. Each state shows one kind of transition. Idle waits for an input and does not depend on time. Fixed-hold lasts a set number of clocks. Gated-hold lasts a minimum number of clocks and then also waits for a condition. Exit returns to idle with no condition. The next state depends only on the registered state, the timer and the inputs, and the outputs are the state code and the timer value.

All timed states share one up-counting timer. The timer clears whenever the state is about to change, so each state starts counting at zero. It also stops at the terminal count of the current state and holds there. Because it holds, a late release of the gated-hold condition is seen on the very next edge. A timer that wrapped around would make that release wait a full lap. The durations of the two timed states and the timer width are parameters. The defaults are 25 clocks for fixed-hold and 8 clocks for gated-hold, with a 5-bit timer.

Top module: `tsm_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `state_o` is 2'b00 (idle) and `timer_o` is 0.
- R2: In idle, `timer_o` stays 0 while `start` is 0. The first rising edge with `start` = 1 moves the machine to fixed-hold (2'b01).
- R3: Fixed-hold lasts exactly FIXED_LEN clock cycles whatever `start` and `stay` do. During that time `timer_o` reads 0, 1, ..., FIXED_LEN-1, one value per cycle. The machine then enters gated-hold (2'b10).
- R4: In gated-hold, `timer_o` counts up from 0 and stops at GATED_LEN-1. It holds that value for as long as the machine remains in gated-hold.
- R5: Gated-hold moves to exit (2'b11) on the first rising edge where `timer_o` equals GATED_LEN-1 and `stay` is 0. If `stay` is 0 before that count, it has no effect, so gated-hold always lasts at least GATED_LEN cycles.
- R6: Exit lasts exactly one cycle with `timer_o` at 0, and the machine then returns to idle (2'b00).
- R7: On every edge that changes the state, the timer goes to 0, so the first cycle of every state shows `timer_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave idle when 1 |
| stay | input | 1 | Keeps the machine in gated-hold while 1; release with 0 |
| state_o | output | 2 | State code: 00 idle, 01 fixed-hold, 10 gated-hold, 11 exit |
| timer_o | output | CNT_W | Current value of the shared timer |

## Verification
Two events can fall in the same cycle in gated-hold: the timer reaching its terminal count, and the release of `stay`. The bench drops `stay` on exactly the cycle the timer first shows GATED_LEN-1 and expects gated-hold to last exactly GATED_LEN cycles. It also pulses `stay` low one cycle too early and expects no exit. Finally it holds `stay` high long past the terminal count and then releases it. The exit must come on the next edge and the timer must stay frozen at the terminal value, which shows that it neither wraps nor overflows.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Binary state code; the encoding is visible on the state_o port.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FIXED = 2'b01,
        ST_GATED = 2'b10,
        ST_EXIT  = 2'b11
    } tsm_state_e;

endpackage

// File: rtl/tsm_timer.sv
module tsm_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    assign at_limit = (tmr_q.cnt == limit);
    assign count    = tmr_q.cnt;

    // Clear wins over everything; otherwise count up and stop at the limit.
    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (!at_limit) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/tsm_next.sv
module tsm_next
    import tsm_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int FIXED_LEN = 25,
    parameter int GATED_LEN = 8
) (
    input  tsm_state_e       state_q,
    input  logic             at_limit,
    input  logic             start,
    input  logic             stay,
    output tsm_state_e       state_d,
    output logic [CNT_W-1:0] limit,
    output logic             change
);

    localparam logic [CNT_W-1:0] FIXED_MAX = CNT_W'(FIXED_LEN - 1);
    localparam logic [CNT_W-1:0] GATED_MAX = CNT_W'(GATED_LEN - 1);

    // Terminal count of the current state; the untimed states use 0.
    always_comb begin
        unique case (state_q)
            ST_FIXED: limit = FIXED_MAX;
            ST_GATED: limit = GATED_MAX;
            default:  limit = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)              state_d = ST_FIXED;
            ST_FIXED: if (at_limit)           state_d = ST_GATED;
            ST_GATED: if (at_limit && !stay)  state_d = ST_EXIT;
            ST_EXIT:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    assign change = (state_d != state_q);

endmodule

// File: rtl/tsm_top.sv
module tsm_top
    import tsm_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int FIXED_LEN = 25,
    parameter int GATED_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stay,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] timer_o
);

    typedef struct packed {
        tsm_state_e state;
    } fsm_regs_t;

    fsm_regs_t        fsm_d, fsm_q;
    tsm_state_e       nxt_state;
    logic [CNT_W-1:0] tmr_limit;
    logic             tmr_at_limit;
    logic             st_change;
    logic [CNT_W-1:0] tmr_count;

    tsm_next #(
        .CNT_W    (CNT_W),
        .FIXED_LEN(FIXED_LEN),
        .GATED_LEN(GATED_LEN)
    ) u_next (
        .state_q (fsm_q.state),
        .at_limit(tmr_at_limit),
        .start   (start),
        .stay    (stay),
        .state_d (nxt_state),
        .limit   (tmr_limit),
        .change  (st_change)
    );

    tsm_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (st_change),
        .limit   (tmr_limit),
        .count   (tmr_count),
        .at_limit(tmr_at_limit)
    );

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.state = nxt_state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= '{state: ST_IDLE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;
    assign timer_o = tmr_count;

endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
    parameter int CNT_W     = 5,
    parameter int FIXED_LEN = 25,
    parameter int GATED_LEN = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stay,
    input logic [1:0]       state,
    input logic [CNT_W-1:0] timer
);

    localparam logic [CNT_W-1:0] FMAX = CNT_W'(FIXED_LEN - 1);
    localparam logic [CNT_W-1:0] GMAX = CNT_W'(GATED_LEN - 1);

    AST_IDLE_TIMER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00) |-> (timer == '0));                                   // R2
    AST_IDLE_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && start) |=> (state == 2'b01 && timer == '0));        // R2
    AST_FIXED_STAY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && timer != FMAX) |=> (state == 2'b01 && timer == $past(timer) + 1'b1)); // R3
    AST_FIXED_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && timer == FMAX) |=> (state == 2'b10));               // R3
    AST_GATED_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10) |-> (timer <= GMAX));                                 // R4
    AST_GATED_SAT: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && timer == GMAX && stay) |=> (state == 2'b10 && timer == GMAX)); // R4
    AST_GATED_EARLY: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && timer != GMAX) |=> (state == 2'b10));               // R5
    AST_GATED_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && timer == GMAX && !stay) |=> (state == 2'b11));      // R5
    AST_EXIT_ONE: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11) |-> (timer == '0) ##1 (state == 2'b00));              // R6
    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> (timer == '0));                            // R7

endmodule

bind tsm_top tsm_checker #(
    .CNT_W    (CNT_W),
    .FIXED_LEN(FIXED_LEN),
    .GATED_LEN(GATED_LEN)
) u_tsm_checker (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .stay (stay),
    .state(state_o),
    .timer(timer_o)
);

// File: tb/tb_tsm_top.sv
module tb_tsm_top;

    localparam int CNT_W     = 5;
    localparam int FIXED_LEN = 25;
    localparam int GATED_LEN = 8;
    localparam int LIMIT_CYC = 200000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             stay = 1'b1;
    logic [1:0]       state_o;
    logic [CNT_W-1:0] timer_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tsm_top #(
        .CNT_W    (CNT_W),
        .FIXED_LEN(FIXED_LEN),
        .GATED_LEN(GATED_LEN)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stay   (stay),
        .state_o(state_o),
        .timer_o(timer_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; stay = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // From idle: pulse start, then spend the whole fixed-hold state.
    task automatic enter_gated();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && state_o == 2'b01; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(state_o == 2'b00, "R1", "state after reset", state_o, 0);
        chk(timer_o == '0,    "R1", "timer after reset", timer_o, 0);
    endtask

    task automatic t_idle();
        bit ok = 1'b1;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (state_o != 2'b00 || timer_o != '0) ok = 1'b0;
        end
        chk(ok, "R2", "idle without start", state_o, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(state_o == 2'b01, "R2", "state after start", state_o, 1);
        chk(timer_o == '0,    "R7", "timer on entering fixed-hold", timer_o, 0);
    endtask

    task automatic t_fixed();
        int n = 0;
        bit seq_ok = 1'b1;
        do_reset();
        start = 1'b1;
        @(negedge clk);
        while (state_o == 2'b01 && n < 200) begin
            if (timer_o != CNT_W'(n)) seq_ok = 1'b0;
            start = n[0];          // inputs toggled: must not matter
            stay  = n[1];
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(seq_ok, "R3", "fixed-hold timer sequence", timer_o, n);
        chk(n == FIXED_LEN, "R3", "fixed-hold length", n, FIXED_LEN);
        chk(state_o == 2'b10, "R3", "state after fixed-hold", state_o, 2);
        chk(timer_o == '0,    "R7", "timer on entering gated-hold", timer_o, 0);
    endtask

    task automatic t_gated_min();
        int n = 0;
        do_reset();
        stay = 1'b0;
        enter_gated();
        while (state_o == 2'b10 && n < 200) begin n++; @(negedge clk); end
        chk(n == GATED_LEN, "R5", "gated-hold length with stay low", n, GATED_LEN);
        chk(state_o == 2'b11, "R6", "exit state reached", state_o, 3);
        chk(timer_o == '0,    "R6", "timer in exit", timer_o, 0);
        @(negedge clk);
        chk(state_o == 2'b00, "R6", "back to idle after one cycle", state_o, 0);
        stay = 1'b1;
    endtask

    task automatic t_gated_late();
        bit ok = 1'b1;
        do_reset();
        stay = 1'b1;
        enter_gated();
        for (int i = 0; i < 20; i++) begin
            int e = (i < GATED_LEN - 1) ? i : GATED_LEN - 1;
            if (state_o != 2'b10 || timer_o != CNT_W'(e)) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R4", "gated-hold saturating count", timer_o, GATED_LEN - 1);
        chk(state_o == 2'b10, "R4", "still gated after long stay", state_o, 2);
        stay = 1'b0;
        @(negedge clk);
        chk(state_o == 2'b11, "R5", "late release exits next edge", state_o, 3);
        stay = 1'b1;
    endtask

    task automatic t_coincide();
        int n = 0;
        do_reset();
        stay = 1'b1;
        enter_gated();
        // Release exactly when the timer first shows the terminal count.
        while (state_o == 2'b10 && n < 200) begin
            stay = (timer_o == CNT_W'(GATED_LEN - 1)) ? 1'b0 : 1'b1;
            n++;
            @(negedge clk);
        end
        chk(n == GATED_LEN, "R5", "release on terminal count", n, GATED_LEN);
        stay = 1'b1;

        // Early single-cycle low pulse must be ignored.
        do_reset();
        stay = 1'b1;
        enter_gated();
        for (int i = 0; i < GATED_LEN - 1; i++) begin
            stay = (i == GATED_LEN - 2) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        stay = 1'b1;
        @(negedge clk);
        chk(state_o == 2'b10, "R5", "early pulse ignored", state_o, 2);
        chk(timer_o == CNT_W'(GATED_LEN - 1), "R4", "timer held at terminal", timer_o, GATED_LEN - 1);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_fixed();
        t_gated_min();
        t_gated_late();
        t_coincide();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (LIMIT_CYC) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule